// File: doc/BRIEF.md
# Butterfly Self-Routing Switch Fabric

This block is a multistage indirect switch that joins 2^D source ports to 2^D sink ports through D+1 ranks of 2^D registered switches each. Every message carries a D-bit destination address and a fixed-width payload. Rank 0 only captures the message. Each later rank k (1..D) reads the most significant bit still left in the header. It sets bit D-k of the column index to that bit, which means it either keeps the column (straight edge) or flips that one column bit (cross edge). It then drops the bit from the header before forwarding. After D steering ranks the column equals the destination, so no routing table is kept anywhere.

Each switch has two incoming edges from the rank above. When both edges carry a head message that wants this switch in the same cycle, a one-bit round-robin pointer picks the winner. The loser stays in its own register and holds its data, and backpressure flows upstream through the ready signals. Every port on both sides uses a valid/ready handshake. A message moves when valid and ready are both high on a rising clock edge.

Top module: `bfly_fabric`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every out_valid bit is 0 and every in_ready bit is 1.
- R2: A message that meets no contention is accepted on one rising edge and is presented on out_valid after D further rising edges. The span from the accepting edge to the delivering edge is therefore D+1 cycles.
- R3: Port j takes its destination from in_dest[j*D +: D]. The most significant of those bits steers rank 1 and the least significant steers rank D. The message leaves on the output whose index equals that destination, and out_data there equals the in_data[j*W +: W] that was accepted.
- R4: The identity pattern (every source j sends to j) and the complement pattern (every source j sends to j XOR (2^D-1)) cause no contention. When all sources send in the same cycle, all 2^D messages are delivered with the R2 latency.
- R5: When two messages ask for the same switch in the same cycle, one advances and the other waits in its register. The waiting message is delivered exactly one cycle after its uncontended latency, and neither message is lost or duplicated.
- R6: After reset, the straight-edge input wins the first contention at any switch. After that, whenever both inputs contend, the input that lost the previous contention at that switch wins.
- R7: When out_ready stays low, one source-to-sink path accepts exactly D+1 messages and then holds in_ready low. After release, the messages leave in the order they were accepted.
- R8: While out_valid is 1 and out_ready is 0 on an output, that output keeps out_valid at 1 and out_data unchanged on the next cycle.
- R9: Under random sources, destinations and sink stalls, every accepted message is delivered exactly once, at its destination. The fabric never holds more than (D+1)*2^D messages and never presents more messages than it has accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2^D | Per-source message valid |
| in_ready | output | 2^D | Per-source capture register free |
| in_dest | input | 2^D*D | Per-source destination address, D bits per port |
| in_data | input | 2^D*W | Per-source payload, W bits per port |
| out_valid | output | 2^D | Per-sink message valid |
| out_ready | input | 2^D | Per-sink accept |
| out_data | output | 2^D*W | Per-sink payload, W bits per port |

## Verification
A lone message, and sweeps from one corner source to every sink, test the steering bit order and the header stripping on their own. The identity and complement patterns load every switch at once, one using only straight edges and the other only cross edges, so a wrong cross-edge mask shows up as a collision or a misroute. Two sources that meet at rank 1 and two streams that meet at the last rank separate a correct round-robin pointer from a fixed priority or a lost message. A blocked sink and a random mix with random sink stalls test backpressure, path depth, ordering and exactly-once delivery.

// File: rtl/bfly_fabric.sv
module bfly_fabric #(
  parameter int D = 3,
  parameter int W = 8,
  localparam int N = 1 << D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  output logic [N-1:0]   in_ready,
  input  logic [N*D-1:0] in_dest,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]   out_valid,
  input  logic [N-1:0]   out_ready,
  output logic [N*W-1:0] out_data
);

  logic         v    [0:D][0:N-1];
  logic [D-1:0] hd   [0:D-1][0:N-1];
  logic [W-1:0] pd   [0:D][0:N-1];
  logic         room [0:D][0:N-1];
  logic         take [0:D][0:N-1];
  logic         gs   [1:D][0:N-1];
  logic         gc   [1:D][0:N-1];

  for (genvar k = 0; k <= D; k++) begin : g_rank
    for (genvar j = 0; j < N; j++) begin : g_col
      assign room[k][j] = !v[k][j] || take[k][j];

      if (k == 0) begin : g_entry
        assign in_ready[j] = room[0][j];
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) v[0][j] <= 1'b0;
          else if (room[0][j]) v[0][j] <= in_valid[j];
        always_ff @(posedge clk)
          if (room[0][j] && in_valid[j]) begin
            hd[0][j] <= in_dest[j*D +: D];
            pd[0][j] <= in_data[j*W +: W];
          end
      end else begin : g_steer
        localparam int P = D - k;
        localparam int X = j ^ (1 << P);
        localparam logic SIDE = 1'((j >> P) & 1);
        logic rs, rc, rr;
        assign rs = v[k-1][j] && (hd[k-1][j][D-1] == SIDE);
        assign rc = v[k-1][X] && (hd[k-1][X][D-1] == SIDE);
        assign gs[k][j] = room[k][j] && rs && (!rc || !rr);
        assign gc[k][j] = room[k][j] && rc && (!rs || rr);

        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            v[k][j] <= 1'b0;
            rr      <= 1'b0;
          end else if (room[k][j]) begin
            v[k][j] <= rs || rc;
            if (rs && rc) rr <= gs[k][j];
          end

        if (k < D) begin : g_hdr
          always_ff @(posedge clk)
            if (gs[k][j])      hd[k][j] <= hd[k-1][j] << 1;
            else if (gc[k][j]) hd[k][j] <= hd[k-1][X] << 1;
        end
        always_ff @(posedge clk)
          if (gs[k][j])      pd[k][j] <= pd[k-1][j];
          else if (gc[k][j]) pd[k][j] <= pd[k-1][X];
      end

      if (k < D) begin : g_fwd
        assign take[k][j] = gs[k+1][j] || gc[k+1][j ^ (1 << (D-k-1))];
      end else begin : g_out
        assign take[k][j]          = v[D][j] && out_ready[j];
        assign out_valid[j]        = v[D][j];
        assign out_data[j*W +: W]  = pd[D][j];
      end
    end
  end

endmodule

module bfly_fabric_chk #(
  parameter int D = 3,
  parameter int W = 8,
  localparam int N = 1 << D
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   in_valid,
  input logic [N-1:0]   in_ready,
  input logic [N*D-1:0] in_dest,
  input logic [N*W-1:0] in_data,
  input logic [N-1:0]   out_valid,
  input logic [N-1:0]   out_ready,
  input logic [N*W-1:0] out_data
);

  logic [31:0] held;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= '0;
    else held <= held + 32'($countones(in_valid & in_ready))
                      - 32'($countones(out_valid & out_ready));

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&in_ready));
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0));
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 32'(N*(D+1)));
  a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    32'($countones(out_valid)) <= held);

  for (genvar j = 0; j < N; j++) begin : g_hold
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] && !out_ready[j] |=> out_valid[j] && $stable(out_data[j*W +: W]));
  end

  logic unused_ok;
  assign unused_ok = ^{in_dest, in_data, in_valid};

endmodule

bind bfly_fabric bfly_fabric_chk #(.D(D), .W(W)) u_chk (.*);

// File: tb/bfly_fabric_bench.sv
`timescale 1ns/1ps
module bfly_fabric_bench;
  localparam int D = 3;
  localparam int W = 8;
  localparam int N = 1 << D;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [N*D-1:0] in_dest = '0;
  logic [N*W-1:0] in_data = '0, out_data;

  bfly_fabric #(.D(D), .W(W)) u_bfly_fabric (.*);

  always #2 clk = ~clk;

  int cyc = 0, nchk = 0, nerr = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int got_n [256], got_out [256], got_cyc [256], acc_cyc [256];
  int ord [N][64];
  int ocnt [N];
  int m_src [256], m_dst [256];
  int m_n;
  bit rnd_rdy = 0;

  always @(negedge clk) if (rst_n) begin
    for (int j = 0; j < N; j++)
      if (out_valid[j] && out_ready[j]) begin
        int id;
        id = int'(out_data[j*W +: W]);
        got_n[id]++;
        got_out[id] = j;
        got_cyc[id] = cyc;
        if (ocnt[j] < 64) begin ord[j][ocnt[j]] = id; ocnt[j]++; end
      end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = '0; in_dest = '0; in_data = '0; out_ready = '1; rnd_rdy = 0;
    for (int i = 0; i < 256; i++) begin got_n[i] = 0; got_out[i] = -1; got_cyc[i] = 0; acc_cyc[i] = 0; end
    for (int j = 0; j < N; j++) ocnt[j] = 0;
    m_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic add(int s, int d);
    m_src[m_n] = s; m_dst[m_n] = d; m_n++;
  endtask

  task automatic issue();
    int ptr [N];
    bit busy;
    for (int j = 0; j < N; j++) begin
      ptr[j] = 0;
      while (ptr[j] < m_n && m_src[ptr[j]] != j) ptr[j]++;
    end
    busy = 1;
    while (busy) begin
      @(posedge clk); #1;
      if (rnd_rdy) out_ready = N'($urandom);
      busy = 0;
      for (int j = 0; j < N; j++)
        if (ptr[j] < m_n) begin
          busy = 1;
          in_valid[j] = 1;
          in_dest[j*D +: D] = D'(m_dst[ptr[j]]);
          in_data[j*W +: W] = W'(ptr[j]);
        end else in_valid[j] = 0;
      @(negedge clk);
      for (int j = 0; j < N; j++)
        if (in_valid[j] && in_ready[j]) begin
          acc_cyc[ptr[j]] = cyc;
          ptr[j]++;
          while (ptr[j] < m_n && m_src[ptr[j]] != j) ptr[j]++;
        end
    end
    in_valid = '0;
    out_ready = '1;
  endtask

  task automatic drain();
    int c;
    bit all;
    c = 0; all = 0;
    while (!all && c < 2000) begin
      @(negedge clk); c++;
      all = 1;
      for (int i = 0; i < m_n; i++) if (got_n[i] == 0) all = 0;
    end
    repeat (2*(D+2)) @(negedge clk);
  endtask

  task automatic verify(string req, bit lat);
    for (int i = 0; i < m_n; i++) begin
      check(got_n[i] == 1, req, $sformatf("msg %0d delivery count", i), got_n[i], 1);
      check(got_out[i] == m_dst[i], req, $sformatf("msg %0d output", i), got_out[i], m_dst[i]);
      if (lat) check(got_cyc[i] - acc_cyc[i] == D+1, req, $sformatf("msg %0d latency", i),
                     got_cyc[i] - acc_cyc[i], D+1);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == '1, "R1", "in_ready after reset", int'(in_ready), N-1);
  endtask

  task automatic t_single();
    int tot;
    do_reset();
    add(2, 5);
    issue(); drain();
    verify("R2", 1);
    tot = 0;
    for (int j = 0; j < N; j++) tot += ocnt[j];
    check(tot == 1, "R3", "total deliveries", tot, 1);
  endtask

  task automatic t_pattern(bit cmp);
    do_reset();
    for (int j = 0; j < N; j++) add(j, cmp ? (j ^ (N-1)) : j);
    issue(); drain();
    verify("R4", 1);
  endtask

  task automatic t_sweep();
    do_reset();
    for (int d = 0; d < N; d++) begin add(0, d); add(N-1, d); end
    issue(); drain();
    verify("R3", 0);
  endtask

  task automatic t_conflict();
    do_reset();
    add(0, 3); add(4, 3);
    issue(); drain();
    check(got_n[0] == 1 && got_n[1] == 1, "R5", "both delivered", got_n[0] + got_n[1], 2);
    check(got_cyc[0] - acc_cyc[0] == D+1, "R5", "winner latency", got_cyc[0] - acc_cyc[0], D+1);
    check(got_cyc[1] - acc_cyc[1] == D+2, "R5", "loser latency", got_cyc[1] - acc_cyc[1], D+2);
    check(got_out[1] == 3, "R5", "loser output", got_out[1], 3);
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < 3; i++) begin add(0, 0); add(1, 0); end
    issue(); drain();
    check(ocnt[0] == 6, "R6", "deliveries at output 0", ocnt[0], 6);
    for (int i = 0; i < 6; i++)
      check(ord[0][i] == i, "R6", $sformatf("order slot %0d", i), ord[0][i], i);
  endtask

  task automatic t_backpressure();
    int nacc, first;
    do_reset();
    out_ready = ~N'(1 << 6);
    nacc = 0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #1;
      in_valid[6] = 1; in_dest[6*D +: D] = D'(6); in_data[6*W +: W] = W'(nacc);
      @(negedge clk);
      if (in_ready[6]) nacc++;
    end
    check(nacc == D+1, "R7", "accepted while blocked", nacc, D+1);
    check(in_ready[6] == 0, "R7", "in_ready while full", int'(in_ready[6]), 0);
    first = int'(out_data[6*W +: W]);
    check(out_valid[6] == 1 && first == 0, "R8", "held head data", first, 0);
    repeat (5) @(negedge clk);
    check(out_valid[6] == 1, "R8", "valid held", int'(out_valid[6]), 1);
    check(int'(out_data[6*W +: W]) == first, "R8", "data stable", int'(out_data[6*W +: W]), first);
    @(posedge clk); #1;
    in_valid = '0; out_ready = '1;
    repeat (3*(D+2)) @(negedge clk);
    check(ocnt[6] == D+1, "R7", "drained count", ocnt[6], D+1);
    for (int i = 0; i < D+1 && i < ocnt[6]; i++)
      check(ord[6][i] == i, "R7", $sformatf("drain order %0d", i), ord[6][i], i);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 200; i++) add(int'($urandom % N), int'($urandom % N));
    rnd_rdy = 1;
    issue(); rnd_rdy = 0; drain();
    verify("R9", 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_pattern(0);
    t_pattern(1);
    t_sweep();
    t_conflict();
    t_rr();
    t_backpressure();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nchk++; nerr++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule